// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block is a bus master for the two-wire management interface of Ethernet PHYs. Software programs a handful of registers through a simple host port: a framing-mode bit, a PHY and register/device address, a 16-bit data word and a command. Each accepted command makes the block send exactly one management frame on the MDC/MDIO pins, in either the Clause 22 or the Clause 45 format. A Clause 45 access therefore takes two commands: an address frame, then a read or write frame.

MDC is derived from the system clock by a fixed divider and stays low between frames. MDIO is presented as a driven value, an output enable for an external open-drain or tri-state pad, and a separate input. The master releases the line during the turnaround and data bits of a read, captures the 16 bits the PHY returns and places them in the read-data register. A busy flag in the command register is set while a frame is on the wire, and start requests that arrive meanwhile are dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command register reads 0 (busy clear), the read-data register reads 0, MDC is low and the MDIO output enable is low.
- R2: While a frame runs, MDC toggles every MDC_HALF system clock cycles, so one MDC period is 2*MDC_HALF cycles; MDC is low whenever no frame runs.
- R3: A frame is 64 bits sent most significant first, one bit per MDC period: 32 ones, a 2-bit start field (01 for Clause 22, 00 for Clause 45), a 2-bit opcode (Clause 22 read 10, Clause 22 write 01, Clause 45 address 00, Clause 45 write 01, Clause 45 read 11), the PHY address from bits 12:8 of the address register (offset 0x04), the register or device number from bits 4:0 of that register, a 2-bit turnaround and 16 data bits.
- R4: In write and address frames the master drives the turnaround as 1 then 0 and the 16 data bits from bits 15:0 of the write-data register (offset 0x08), keeping the output enable high for all 64 bits.
- R5: In read frames the output enable is high for the first 46 bits and low for the two turnaround bits and the 16 data bits; between frames it is low.
- R6: The master changes MDIO only after a falling MDC edge (or at frame start) and samples MDIO on rising MDC edges; after a read frame the 16 bits sampled in the data field, first bit as bit 15, appear in bits 15:0 of the read-data register (offset 0x10).
- R7: Writing the command register (offset 0x0C) with bit 8 (start) set and a valid access code in bits 2:0 (0 Clause 22 read, 1 Clause 22 write, 2 Clause 45 address, 3 Clause 45 write, 4 Clause 45 read) sets busy, read at bit 16 of that register, from the next cycle until the frame ends; bits 2:0 read back the last accepted code.
- R8: A start written while busy is set is ignored: no extra frame is sent and the code read back is unchanged.
- R9: A start whose code does not belong to the clause chosen by the mode bit (bit 8 of offset 0x00: 1 allows codes 2 to 4, 0 allows codes 0 and 1), or a code of 5 to 7, is ignored.
- R10: The mode bit, the address fields and the write-data word read back at their offsets as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 5 | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The bench builds the block with MDC_HALF set to 2, so a full 64-bit frame lasts 256 system cycles and all five frame kinds, the ignored-start cases and the read-data capture fit in a short run. The small divider also makes the spacing between a falling MDC edge and the next rising edge only two cycles, which exposes any slip in when MDIO is updated or sampled.

// File: rtl/mdio_pkg.sv
// Shared constants, access codes and frame builder for the MDIO master.
// Assumes the fixed 64-bit management frame layout.
package mdio_pkg;
    localparam int HOST_AW   = 5;
    localparam int HOST_DW   = 32;
    localparam int FRAME_LEN = 64;
    localparam int TA_POS    = 46;
    localparam int DATA_POS  = 48;
    localparam int DATA_W    = 16;
    localparam int FLD_W     = 5;

    localparam logic [HOST_AW-1:0] OFS_MODE  = 5'h00;
    localparam logic [HOST_AW-1:0] OFS_ADDR  = 5'h04;
    localparam logic [HOST_AW-1:0] OFS_WDATA = 5'h08;
    localparam logic [HOST_AW-1:0] OFS_CMD   = 5'h0C;
    localparam logic [HOST_AW-1:0] OFS_RDATA = 5'h10;

    typedef enum logic [2:0] {
        ACC_C22_RD  = 3'd0,
        ACC_C22_WR  = 3'd1,
        ACC_C45_ADR = 3'd2,
        ACC_C45_WR  = 3'd3,
        ACC_C45_RD  = 3'd4
    } acc_code_e;

    // True when the code is legal for the clause chosen by the mode bit.
    function automatic logic code_ok(input logic c45, input logic [2:0] code);
        if (c45) return (code == ACC_C45_ADR) || (code == ACC_C45_WR) || (code == ACC_C45_RD);
        else     return (code == ACC_C22_RD) || (code == ACC_C22_WR);
    endfunction

    function automatic logic code_is_read(input logic [2:0] code);
        return (code == ACC_C22_RD) || (code == ACC_C45_RD);
    endfunction

    // Build the full serial frame, MSB first on the wire.
    function automatic logic [FRAME_LEN-1:0] build_frame(input logic [2:0] code,
            input logic [FLD_W-1:0] phy, input logic [FLD_W-1:0] fld,
            input logic [DATA_W-1:0] data);
        logic [1:0] st, op, ta;
        logic [DATA_W-1:0] dat;
        st = (code == ACC_C22_RD || code == ACC_C22_WR) ? 2'b01 : 2'b00;
        case (code)
            ACC_C22_RD:  op = 2'b10;
            ACC_C22_WR:  op = 2'b01;
            ACC_C45_WR:  op = 2'b01;
            ACC_C45_RD:  op = 2'b11;
            default:     op = 2'b00;
        endcase
        ta  = code_is_read(code) ? 2'b11 : 2'b10;
        dat = code_is_read(code) ? {DATA_W{1'b1}} : data;
        return {32'hFFFF_FFFF, st, op, phy, fld, ta, dat};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC divider: toggles MDC every HALF system cycles while run is high and
// flags the cycle of each rising and falling edge. Assumes HALF >= 1.
module mdio_mdc_gen #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(HALF - 1));
    assign rise = run && wrap && !mdc;
    assign fall = run && wrap && mdc;

    // Count system cycles and flip MDC at each half-period; idle low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: MDC returns low once no frame is running.
    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
// Serialises one 64-bit frame, releasing MDIO for the turnaround and data
// of reads and capturing the returned data. Assumes rise/fall strobes
// never coincide and arrive only while busy.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 rd_op,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_W-1:0]    rx_data,
    output logic                 rx_valid
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    logic [FRAME_LEN-1:0] tx;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 rd_q;

    assign mdio_o = tx[FRAME_LEN-1];

    // Load on start, count rising edges, capture data, advance on falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx       <= '0;
            bit_cnt  <= '0;
            rd_q     <= 1'b0;
            busy     <= 1'b0;
            mdio_oe  <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (start && !busy) begin
                tx      <= frame;
                bit_cnt <= '0;
                rd_q    <= rd_op;
                busy    <= 1'b1;
                mdio_oe <= 1'b1;
            end else if (busy) begin
                if (rise) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt >= CNT_W'(DATA_POS))
                        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
                end
                if (fall) begin
                    if (bit_cnt == CNT_W'(FRAME_LEN)) begin
                        busy     <= 1'b0;
                        mdio_oe  <= 1'b0;
                        tx       <= '0;
                        rx_valid <= rd_q;
                    end else begin
                        tx      <= tx << 1;
                        mdio_oe <= !(rd_q && bit_cnt >= CNT_W'(TA_POS));
                    end
                end
            end
        end
    end

    // R6: the driven value moves only at a falling MDC edge or at frame start.
    a_r6_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $past(fall || (start && !busy)));
    // R7: busy ends only after all 64 bits have been clocked.
    a_r7_busy_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_cnt) == CNT_W'(FRAME_LEN));
    // R8: the register stage never passes a start while a frame runs.
    a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R5: the line is released whenever no frame runs.
    a_r5_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
// Register-programmed MDIO master. Holds the host-visible registers,
// accepts one start per idle period and hands the frame to the engine.
// Assumes software waits for busy clear before reprogramming.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    logic              mode_c45;
    logic [FLD_W-1:0]  phy_q, fld_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, rx_data;
    logic [2:0]        code_q;
    logic              busy, rx_valid, rise, fall, go;
    logic [2:0]        new_code;
    logic              unused_bits;

    assign new_code    = host_wdata[2:0];
    assign go          = host_wr && (host_addr == OFS_CMD) && host_wdata[8]
                         && !busy && code_ok(mode_c45, new_code);
    assign unused_bits = ^{host_wdata[31:16], host_wdata[7:5]};

    // Host register writes and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_c45 <= 1'b0;
            phy_q    <= '0;
            fld_q    <= '0;
            wdata_q  <= '0;
            code_q   <= '0;
            rdata_q  <= '0;
        end else begin
            if (host_wr && host_addr == OFS_MODE)  mode_c45 <= host_wdata[8];
            if (host_wr && host_addr == OFS_ADDR) begin
                phy_q <= host_wdata[12:8];
                fld_q <= host_wdata[4:0];
            end
            if (host_wr && host_addr == OFS_WDATA) wdata_q <= host_wdata[15:0];
            if (go)                                code_q  <= new_code;
            if (rx_valid)                          rdata_q <= rx_data;
        end
    end

    // Host read multiplexer.
    always_comb begin
        case (host_addr)
            OFS_MODE:  host_rdata = {23'b0, mode_c45, 8'b0};
            OFS_ADDR:  host_rdata = {19'b0, phy_q, 3'b0, fld_q};
            OFS_WDATA: host_rdata = {16'b0, wdata_q};
            OFS_CMD:   host_rdata = {15'b0, busy, 13'b0, code_q};
            OFS_RDATA: host_rdata = {16'b0, rdata_q};
            default:   host_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go),
        .rd_op   (code_is_read(new_code)),
        .frame   (build_frame(new_code, phy_q, fld_q, wdata_q)),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rx_data (rx_data),
        .rx_valid(rx_valid)
    );

    // R9: an accepted start always carries a code legal for the current mode.
    a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> code_ok(mode_c45, code_q));
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
// Scoreboard bench: the driver queues the expected wire frame, a monitor
// rebuilds each frame from MDC rising edges and compares it.
module mdio_mgmt_master_tb_top;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0, n_bad = 0;
    logic [63:0] q_line[$];
    logic [63:0] q_oe[$];
    logic        phy_rd = 1'b0;
    logic [15:0] phy_val = '0;
    logic        phy_drv = 1'b1;
    int          frames = 0;
    longint      cyc = 0;

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    mdio_mgmt_master #(.MDC_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    // Monitor and PHY model, away from the active edge.
    logic        mdc_q = 1'b0;
    int          rises = 0;
    logic [63:0] sh_line, sh_oe;
    longint      last_rise = 0;
    bit          per_checked = 0;
    always @(negedge clk) begin
        if (mdc && !mdc_q) begin
            sh_line = {sh_line[62:0], mdio_i};
            sh_oe   = {sh_oe[62:0], mdio_oe};
            if (rises == 1 && !per_checked) begin
                check("R2 mdc period", 64'(cyc - last_rise), 64'(2 * HALF));
                per_checked = 1;
            end
            last_rise = cyc;
            rises++;
            if (rises == 64) begin
                frames++;
                if (q_line.size() == 0) begin
                    check("R8 unexpected frame", 64'(frames), 64'(0));
                end else begin
                    check("R3 R4 frame bits", sh_line, q_line.pop_front());
                    check("R5 drive enable pattern", sh_oe, q_oe.pop_front());
                end
            end
        end
        if (!mdc && mdc_q) begin
            if (rises == 64) begin
                rises = 0;
                phy_drv = 1'b1;
            end else if (phy_rd && rises == 47) phy_drv = 1'b0;
            else if (phy_rd && rises >= 48)     phy_drv = phy_val[63 - rises];
            else                                phy_drv = 1'b1;
        end
        mdc_q = mdc;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            rd(5'h0C, v);
            if (!v[16]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // Driver: compute the expected wire image and queue it.
    task automatic push_frame(input logic [1:0] st, input logic [1:0] op,
            input logic [4:0] phy, input logic [4:0] fld,
            input logic rdf, input logic [15:0] dat);
        logic [63:0] ln, oe;
        ln = {32'hFFFF_FFFF, st, op, phy, fld, (rdf ? 2'b10 : 2'b10), dat};
        oe = rdf ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        q_line.push_back(ln);
        q_oe.push_back(oe);
    endtask

    initial begin
        logic [31:0] v;
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(5'h0C, v); check("R1 cmd reg", 64'(v), 64'h0);
        rd(5'h10, v); check("R1 read-data reg", 64'(v), 64'h0);
        check("R1 mdc low", 64'(mdc), 64'h0);
        check("R1 oe low", 64'(mdio_oe), 64'h0);

        // R10 register readback
        wr(5'h00, 32'h0000_0100); rd(5'h00, v); check("R10 mode", 64'(v), 64'h100);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0000_0A13); rd(5'h04, v); check("R10 addr", 64'(v), 64'h0A13);
        wr(5'h08, 32'h0000_BEEF); rd(5'h08, v); check("R10 wdata", 64'(v), 64'hBEEF);

        // Clause 22 write
        wr(5'h04, 32'h0000_0503);
        push_frame(2'b01, 2'b01, 5'h05, 5'h03, 1'b0, 16'hBEEF);
        wr(5'h0C, 32'h0000_0101);
        rd(5'h0C, v); check("R7 busy after start", 64'(v[16]), 64'h1);
        check("R7 code readback", 64'(v[2:0]), 64'h1);
        wait_idle();
        rd(5'h0C, v); check("R7 busy clear", 64'(v[16]), 64'h0);
        check("R5 oe low after frame", 64'(mdio_oe), 64'h0);
        check("R2 mdc idle low", 64'(mdc), 64'h0);

        // Clause 22 read with a start written while busy (R8)
        phy_rd = 1'b1; phy_val = 16'h9C31;
        push_frame(2'b01, 2'b10, 5'h05, 5'h03, 1'b1, 16'h9C31);
        f0 = frames;
        wr(5'h0C, 32'h0000_0100);
        wr(5'h0C, 32'h0000_0101);
        rd(5'h0C, v); check("R8 code kept while busy", 64'(v[2:0]), 64'h0);
        wait_idle();
        repeat (20) @(negedge clk);
        check("R8 one frame only", 64'(frames - f0), 64'h1);
        rd(5'h10, v); check("R6 c22 read data", 64'(v), 64'h9C31);
        phy_rd = 1'b0;

        // Clause 45 address then write
        wr(5'h00, 32'h0000_0100);
        wr(5'h04, 32'h0000_111E);
        wr(5'h08, 32'h0000_1234);
        push_frame(2'b00, 2'b00, 5'h11, 5'h1E, 1'b0, 16'h1234);
        wr(5'h0C, 32'h0000_0102);
        wait_idle();
        wr(5'h08, 32'h0000_5A5A);
        push_frame(2'b00, 2'b01, 5'h11, 5'h1E, 1'b0, 16'h5A5A);
        wr(5'h0C, 32'h0000_0103);
        wait_idle();

        // Clause 45 read
        phy_rd = 1'b1; phy_val = 16'hC3A5;
        push_frame(2'b00, 2'b11, 5'h11, 5'h1E, 1'b1, 16'hC3A5);
        wr(5'h0C, 32'h0000_0104);
        wait_idle();
        rd(5'h10, v); check("R6 c45 read data", 64'(v), 64'hC3A5);
        phy_rd = 1'b0;

        // R9 illegal codes for the mode
        f0 = frames;
        wr(5'h0C, 32'h0000_0100);
        rd(5'h0C, v); check("R9 c22 code in c45 mode", 64'(v), 64'h4);
        wr(5'h0C, 32'h0000_0107);
        rd(5'h0C, v); check("R9 code 7", 64'(v), 64'h4);
        wr(5'h00, 32'h0);
        wr(5'h0C, 32'h0000_0103);
        rd(5'h0C, v); check("R9 c45 code in c22 mode", 64'(v), 64'h4);
        repeat (300) @(negedge clk);
        check("R9 no frame sent", 64'(frames - f0), 64'h0);
        check("R9 scoreboard drained", 64'(q_line.size()), 64'h0);
        finish_run();
    end
endmodule